// File: doc/BRIEF.md
# Converter Power Sequencing Controller

This block decides when the core of a serial sampling converter and its internal voltage reference receive power. It also reports whether a conversion started now would give a valid result. It runs on a free-running system clock. The chip-select level and single-cycle strobes marking the rising and falling edges of the serial clock reach it already synchronised to that clock. The active power policy comes from a 2-bit mode field in the control register. Two further register bits matter: one turns off the internal reference, and one selects two-input operation, in which the supply rail serves as the reference.

A frame begins when chip select falls. It ends either on the sixteenth rising serial-clock edge or when chip select returns high. The analog input is sampled on the second rising edge of the frame. Powering up is not instant. The block counts a long settling delay when it wakes from full shutdown with the internal reference in use. It counts a short delay when it wakes from standby, or when the internal reference is not needed. A conversion whose sample edge arrives before that delay has run out is flagged as invalid. A new power mode written while a frame is in progress takes effect only when that frame ends.

Top module: `adc_power_ctrl`

## Requirements
- R1: After reset, with mode field 00 and chip select high, `coreEnable`, `refEnable`, `ready` and `invalidResult` are all 0.
- R2: Mode 00 gates power with chip select. Chip select low powers the core one clock edge later. Chip select high removes power one clock edge later, even in the middle of a conversion.
- R3: Mode 01 keeps the core powered regardless of chip select and of serial-clock activity, including across whole frames.
- R4: Mode 10 leaves the core off when chip select falls. It powers the core on the first falling serial-clock edge of the frame. It removes all power on the 16th rising edge of the frame, and not on the 15th.
- R5: Mode 11 behaves like mode 10, except that after the 16th rising edge the core is off while the reference stays on (standby).
- R6: From power-on, `ready` rises exactly LONG_WAKE_CYCLES clock edges later when waking from full shutdown with the internal reference in use. It rises SHORT_WAKE_CYCLES edges later when waking from standby, or with the reference disabled, or in two-input operation.
- R7: `refEnable` is 0 whenever `refDisable` or `dualChannel` is 1. Otherwise `refEnable` is 1 whenever the core is powered or in standby.
- R8: `ready` is 1 only while the core is powered and its wake delay has expired.
- R9: On each sample edge (the 2nd rising serial-clock edge of a frame), `invalidResult` is set to 1 if `ready` was 0 and cleared to 0 if `ready` was 1. It changes at no other time.
- R10: A mode value written during a frame is ignored until the frame ends. The value present at the frame's end then decides the power state that follows it.
- R11: Serial-clock strobes outside a frame have no effect on power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrMode | input | 2 | Power policy field: 00 chip-select gated, 01 always on, 10 off after frame, 11 standby after frame |
| refDisable | input | 1 | 1 turns the internal reference off |
| dualChannel | input | 1 | 1 selects two-input operation (supply used as reference) |
| csN | input | 1 | Active-low chip select, synchronous |
| sclkRise | input | 1 | One-cycle strobe for a rising serial-clock edge |
| sclkFall | input | 1 | One-cycle strobe for a falling serial-clock edge |
| coreEnable | output | 1 | Power enable for the converter core |
| refEnable | output | 1 | Power enable for the internal reference |
| ready | output | 1 | Core powered and settled |
| invalidResult | output | 1 | The latest sample was taken before settling |

## Verification
Every power decision is registered. The enables and the invalid flag therefore move on the first clock edge after the input or strobe that causes them, and the bench samples one nanosecond after that edge. `ready` is due exactly the wake-delay count of edges after the edge that powered the core. For each delay, the bench checks that `ready` is still low one edge before that point and high on it. Frame-end checks are made after the 15th strobe and again after the 16th, so that an off-by-one in the edge count is caught.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_STANDBY,
    PS_WAKING,
    PS_READY,
    PS_CONVERTING
  } pwrState_t;

  typedef enum logic [1:0] {
    PM_CS_GATED     = 2'b00,
    PM_ALWAYS_ON    = 2'b01,
    PM_AUTO_OFF     = 2'b10,
    PM_AUTO_STANDBY = 2'b11
  } pwrMode_t;

  // strobes from the frame tracker to the power FSM
  typedef struct packed {
    logic inFrame;
    logic endByCount;
    logic endByCs;
    logic sampleEdge;
    logic wakeFall;
  } frameStrobes_t;

  // commands from the power FSM to the wake timer
  typedef struct packed {
    logic loadLong;
    logic loadShort;
  } wakeCmd_t;

endpackage

// File: rtl/adc_pm_frame.sv
module adc_pm_frame
  import adc_pm_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int SAMPLE_EDGE = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclkRise,
  input  logic          sclkFall,
  output frameStrobes_t strobes
);

  localparam int CW = $clog2(FRAME_EDGES + 1);
  localparam logic [CW-1:0] LAST_IDX   = CW'(FRAME_EDGES - 1);
  localparam logic [CW-1:0] SAMPLE_IDX = CW'(SAMPLE_EDGE - 1);

  logic          csPrev;
  logic          inFrame;
  logic          fallSeen;
  logic [CW-1:0] riseCnt;

  logic csFall;
  logic active;
  logic lastRise;
  logic endByCs;

  assign csFall   = csPrev & ~csN;
  assign active   = inFrame & ~csN;
  assign lastRise = active & sclkRise & (riseCnt == LAST_IDX);
  assign endByCs  = inFrame & csN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      inFrame  <= 1'b0;
      fallSeen <= 1'b0;
      riseCnt  <= '0;
    end else begin
      csPrev <= csN;
      if (csFall) begin
        inFrame  <= 1'b1;
        fallSeen <= 1'b0;
        riseCnt  <= '0;
      end else if (endByCs || lastRise) begin
        inFrame <= 1'b0;
      end else if (active) begin
        if (sclkRise) riseCnt <= riseCnt + 1'b1;
        if (sclkFall) fallSeen <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.inFrame    = inFrame;
    strobes.endByCount = lastRise;
    strobes.endByCs    = endByCs;
    strobes.sampleEdge = active & sclkRise & (riseCnt == SAMPLE_IDX);
    strobes.wakeFall   = active & sclkFall & ~fallSeen;
  end

endmodule

// File: rtl/adc_pm_wake_timer.sv
module adc_pm_wake_timer
  import adc_pm_pkg::*;
#(
  parameter int LONG_WAKE_CYCLES  = 1250,
  parameter int SHORT_WAKE_CYCLES = 250
) (
  input  logic     clk,
  input  logic     rstN,
  input  wakeCmd_t cmd,
  output logic     expired
);

  localparam int MAXV = (LONG_WAKE_CYCLES > SHORT_WAKE_CYCLES) ? LONG_WAKE_CYCLES : SHORT_WAKE_CYCLES;
  localparam int CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_WAKE_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_WAKE_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (cmd.loadLong) begin
      remain <= LONG_LOAD;
    end else if (cmd.loadShort) begin
      remain <= SHORT_LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/adc_pm_fsm.sv
module adc_pm_fsm
  import adc_pm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    pwrMode,
  input  logic          refDisable,
  input  logic          dualChannel,
  input  logic          csN,
  input  frameStrobes_t strobes,
  input  logic          expired,
  output wakeCmd_t      cmd,
  output logic          coreEnable,
  output logic          refEnable,
  output logic          ready,
  output logic          invalidResult
);

  pwrState_t state, nextState;
  pwrMode_t  activeMode, effMode;
  logic      frameEnd;
  logic      refNeeded;
  logic      wakeReq;

  assign frameEnd  = strobes.endByCount | strobes.endByCs;
  assign refNeeded = ~refDisable & ~dualChannel;

  // the latched mode holds through a frame; the register value applies outside one and at its end
  always_comb begin
    if (strobes.inFrame && !frameEnd) effMode = activeMode;
    else                              effMode = pwrMode_t'(pwrMode);
  end

  always_comb begin
    case (effMode)
      PM_CS_GATED:  wakeReq = ~csN;
      PM_ALWAYS_ON: wakeReq = 1'b1;
      default:      wakeReq = strobes.wakeFall;
    endcase
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (effMode == PM_CS_GATED && csN) begin
      nextState = PS_OFF;
    end else if (strobes.endByCount && effMode == PM_AUTO_OFF) begin
      nextState = PS_OFF;
    end else if (strobes.endByCount && effMode == PM_AUTO_STANDBY) begin
      nextState = PS_STANDBY;
    end else begin
      case (state)
        PS_OFF, PS_STANDBY: begin
          if (wakeReq) begin
            nextState = PS_WAKING;
            if (state == PS_STANDBY || !refNeeded) cmd.loadShort = 1'b1;
            else                                   cmd.loadLong  = 1'b1;
          end
        end
        PS_WAKING:     if (expired) nextState = PS_READY;
        PS_READY:      if (strobes.sampleEdge) nextState = PS_CONVERTING;
        PS_CONVERTING: if (frameEnd) nextState = PS_READY;
        default:       nextState = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= PS_OFF;
      activeMode    <= PM_CS_GATED;
      invalidResult <= 1'b0;
    end else begin
      state      <= nextState;
      activeMode <= effMode;
      if (strobes.sampleEdge) invalidResult <= (state != PS_READY);
    end
  end

  always_comb begin
    coreEnable = (state == PS_WAKING) || (state == PS_READY) || (state == PS_CONVERTING);
    refEnable  = refNeeded && (state != PS_OFF);
    ready      = (state == PS_READY) || (state == PS_CONVERTING);
  end

endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl
  import adc_pm_pkg::*;
#(
  parameter int LONG_WAKE_CYCLES  = 1250,
  parameter int SHORT_WAKE_CYCLES = 250,
  parameter int FRAME_EDGES       = 16,
  parameter int SAMPLE_EDGE       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwrMode,
  input  logic       refDisable,
  input  logic       dualChannel,
  input  logic       csN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  output logic       coreEnable,
  output logic       refEnable,
  output logic       ready,
  output logic       invalidResult
);

  frameStrobes_t strobes;
  wakeCmd_t      wakeCmd;
  logic          wakeExpired;

  adc_pm_frame #(
    .FRAME_EDGES(FRAME_EDGES),
    .SAMPLE_EDGE(SAMPLE_EDGE)
  ) uFrame (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .strobes (strobes)
  );

  adc_pm_wake_timer #(
    .LONG_WAKE_CYCLES (LONG_WAKE_CYCLES),
    .SHORT_WAKE_CYCLES(SHORT_WAKE_CYCLES)
  ) uTimer (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (wakeCmd),
    .expired(wakeExpired)
  );

  adc_pm_fsm uFsm (
    .clk          (clk),
    .rstN         (rstN),
    .pwrMode      (pwrMode),
    .refDisable   (refDisable),
    .dualChannel  (dualChannel),
    .csN          (csN),
    .strobes      (strobes),
    .expired      (wakeExpired),
    .cmd          (wakeCmd),
    .coreEnable   (coreEnable),
    .refEnable    (refEnable),
    .ready        (ready),
    .invalidResult(invalidResult)
  );

endmodule

// File: rtl/adc_power_ctrl_checker.sv
module adc_power_ctrl_checker #(
  parameter int LONG_WAKE_CYCLES  = 1250,
  parameter int SHORT_WAKE_CYCLES = 250
) (
  input logic clk,
  input logic rstN,
  input logic refDisable,
  input logic dualChannel,
  input logic sclkRise,
  input logic coreEnable,
  input logic refEnable,
  input logic ready,
  input logic invalidResult
);

  localparam int CW = $clog2(LONG_WAKE_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(LONG_WAKE_CYCLES);

  logic [CW-1:0] onCnt;

  // cycles the core has been powered, saturating
  always_ff @(posedge clk) begin
    if (!rstN || !coreEnable) onCnt <= '0;
    else if (onCnt != SAT)    onCnt <= onCnt + 1'b1;
  end

  p_ready_needs_core_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> coreEnable);

  p_wake_min_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (int'(onCnt) >= SHORT_WAKE_CYCLES));

  p_ref_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refDisable || dualChannel) |-> !refEnable);

  p_ref_with_core_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coreEnable && !refDisable && !dualChannel) |-> refEnable);

  p_invalid_on_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(invalidResult) |-> $past(sclkRise));

endmodule

bind adc_power_ctrl adc_power_ctrl_checker #(
  .LONG_WAKE_CYCLES (LONG_WAKE_CYCLES),
  .SHORT_WAKE_CYCLES(SHORT_WAKE_CYCLES)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .refDisable   (refDisable),
  .dualChannel  (dualChannel),
  .sclkRise     (sclkRise),
  .coreEnable   (coreEnable),
  .refEnable    (refEnable),
  .ready        (ready),
  .invalidResult(invalidResult)
);

// File: tb/adc_power_ctrl_test.sv
`timescale 1ns/1ps
module adc_power_ctrl_test;

  localparam int LONG_W  = 40;
  localparam int SHORT_W = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwrMode = 2'b00;
  logic       refDisable = 1'b0;
  logic       dualChannel = 1'b0;
  logic       csN = 1'b1;
  logic       sclkRise = 1'b0;
  logic       sclkFall = 1'b0;
  logic       coreEnable, refEnable, ready, invalidResult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_power_ctrl #(
    .LONG_WAKE_CYCLES (LONG_W),
    .SHORT_WAKE_CYCLES(SHORT_W)
  ) uut (
    .clk          (clk),
    .rstN         (rstN),
    .pwrMode      (pwrMode),
    .refDisable   (refDisable),
    .dualChannel  (dualChannel),
    .csN          (csN),
    .sclkRise     (sclkRise),
    .sclkFall     (sclkFall),
    .coreEnable   (coreEnable),
    .refEnable    (refEnable),
    .ready        (ready),
    .invalidResult(invalidResult)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rises(int n);
    for (int i = 0; i < n; i++) begin
      sclkRise = 1'b1;
      tick();
      sclkRise = 1'b0;
    end
  endtask

  task automatic fallOnce();
    sclkFall = 1'b1;
    tick();
    sclkFall = 1'b0;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    waitEdges(3);
    rstN = 1'b1;
    tick();
    check("R1", "coreEnable", coreEnable, 1'b0);
    check("R1", "refEnable", refEnable, 1'b0);
    check("R1", "ready", ready, 1'b0);
    check("R1", "invalidResult", invalidResult, 1'b0);
  endtask

  task automatic testCsGated();
    csN = 1'b0;
    tick();
    check("R2", "core on after cs low", coreEnable, 1'b1);
    check("R7", "ref on with core", refEnable, 1'b1);
    waitEdges(LONG_W - 1);
    check("R6", "ready one edge before long delay", ready, 1'b0);
    tick();
    check("R6", "ready at long delay", ready, 1'b1);
    rises(2);
    check("R8", "ready while converting", ready, 1'b1);
    csN = 1'b1;
    tick();
    check("R2", "core off on cs high mid conversion", coreEnable, 1'b0);
    check("R8", "ready drops with power", ready, 1'b0);
  endtask

  task automatic testAlwaysOn();
    pwrMode = 2'b01;
    tick();
    check("R3", "core on with cs high", coreEnable, 1'b1);
    waitEdges(LONG_W - 1);
    check("R6", "ready before long delay", ready, 1'b0);
    tick();
    check("R6", "ready after long delay", ready, 1'b1);
    csN = 1'b0;
    tick();
    rises(16);
    csN = 1'b1;
    tick();
    check("R3", "core stays on across frame", coreEnable, 1'b1);
    check("R3", "ready stays on across frame", ready, 1'b1);
    pwrMode = 2'b00;
    tick();
    check("R2", "core off when gated mode with cs high", coreEnable, 1'b0);
  endtask

  task automatic testRefOff();
    refDisable = 1'b1;
    csN = 1'b0;
    tick();
    check("R7", "ref off when disabled", refEnable, 1'b0);
    check("R2", "core on", coreEnable, 1'b1);
    waitEdges(SHORT_W - 1);
    check("R6", "ready before short delay (ref disabled)", ready, 1'b0);
    tick();
    check("R6", "ready at short delay (ref disabled)", ready, 1'b1);
    csN = 1'b1;
    tick();
    refDisable = 1'b0;
    dualChannel = 1'b1;
    csN = 1'b0;
    tick();
    check("R7", "ref off in two-input mode", refEnable, 1'b0);
    waitEdges(SHORT_W - 1);
    check("R6", "ready before short delay (two-input)", ready, 1'b0);
    tick();
    check("R6", "ready at short delay (two-input)", ready, 1'b1);
    csN = 1'b1;
    tick();
    dualChannel = 1'b0;
    check("R2", "core off again", coreEnable, 1'b0);
  endtask

  task automatic testAutoOff();
    pwrMode = 2'b10;
    tick();
    fallOnce();
    rises(3);
    check("R11", "strobes outside frame ignored", coreEnable, 1'b0);
    csN = 1'b0;
    tick();
    check("R4", "core stays off on cs fall", coreEnable, 1'b0);
    pwrMode = 2'b01;
    tick();
    check("R10", "mode write mid-frame deferred", coreEnable, 1'b0);
    pwrMode = 2'b10;
    fallOnce();
    check("R4", "core on at first falling edge", coreEnable, 1'b1);
    rises(2);
    check("R9", "early sample flagged invalid", invalidResult, 1'b1);
    waitEdges(LONG_W - 3);
    check("R6", "ready before long delay (auto off)", ready, 1'b0);
    tick();
    check("R6", "ready at long delay (auto off)", ready, 1'b1);
    rises(13);
    check("R4", "core still on after 15th rise", coreEnable, 1'b1);
    rises(1);
    check("R4", "core off after 16th rise", coreEnable, 1'b0);
    check("R4", "ref off after 16th rise", refEnable, 1'b0);
    csN = 1'b1;
    tick();
  endtask

  task automatic testAutoStandby();
    pwrMode = 2'b11;
    tick();
    csN = 1'b0;
    tick();
    fallOnce();
    waitEdges(LONG_W);
    check("R6", "ready after long delay from off", ready, 1'b1);
    rises(2);
    check("R9", "settled sample clears invalid", invalidResult, 1'b0);
    rises(14);
    check("R5", "core off in standby", coreEnable, 1'b0);
    check("R5", "ref kept on in standby", refEnable, 1'b1);
    csN = 1'b1;
    tick();
    csN = 1'b0;
    tick();
    fallOnce();
    check("R5", "core wakes from standby", coreEnable, 1'b1);
    waitEdges(SHORT_W - 1);
    check("R6", "ready before short delay (standby)", ready, 1'b0);
    tick();
    check("R6", "ready at short delay (standby)", ready, 1'b1);
    csN = 1'b1;
    tick();
  endtask

  task automatic testModeAtFrameEnd();
    csN = 1'b0;
    tick();
    fallOnce();
    waitEdges(SHORT_W);
    check("R10", "ready before mode change", ready, 1'b1);
    rises(8);
    pwrMode = 2'b01;
    rises(8);
    check("R10", "new mode governs frame end (core)", coreEnable, 1'b1);
    check("R10", "new mode governs frame end (ready)", ready, 1'b1);
    csN = 1'b1;
    tick();
    check("R3", "stays on after frame", coreEnable, 1'b1);
  endtask

  initial begin
    testReset();
    testCsGated();
    testAlwaysOn();
    testRefOff();
    testAutoOff();
    testAutoStandby();
    testModeAtFrameEnd();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule